// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block watches the health of a 10 Mb/s twisted-pair link and keeps the far end informed that the local station is present. While the local transmitter is idle, it emits a short positive link pulse at a fixed period. On the receive side, the analog front end gives it two single-cycle strobes. One marks a detected link pulse. The other marks a completed valid packet. From these strobes the block runs a pass/fail state machine.

The rules for leaving the fail state differ from the rules for staying in the pass state. In the pass state, a pulse that arrives too soon after the previous one is ignored. If the link stays silent for too long, the block drops to fail. In the fail state, the block counts properly spaced pulses. A pulse that comes too soon wipes that count. The block climbs back to pass after four well-spaced pulses or one good packet, but only once both transmit and receive are quiet.

While failing, the block blocks reception and holds data transmission idle. Link pulses still go out during this time. A test-disable input forces the passing condition. Every timer limit is a parameter counted in clock cycles.

Top module: `link_integrity_ctrl`

## Requirements
- R1: After synchronous reset the block is in the fail state with a zero pulse count: link_pass_n=1, rx_inhibit=1, tx_inhibit=1, sel_tp=0.
- R2: When tx_busy is low, or tx_inhibit is high, lp_out is high for PULSE_WIDTH cycles out of every PULSE_PERIOD cycles. When tx_busy=1 and tx_inhibit=0, lp_out stays low and the period phase restarts from zero.
- R3: In the fail state, link pulses keep being sent whatever the value of tx_busy, and tx_inhibit is 1.
- R4: In the fail state, four consecutive qualified pulses move the block to pass. The state changes two clock edges after the fourth strobe, provided tx_busy and rx_busy are both low at that point. A pulse is qualified when its strobe comes CONSEC_MIN to CONSEC_MAX cycles after the previous strobe.
- R5: In the fail state, one pkt_seen strobe is remembered. The block moves to pass on the first cycle after the strobe in which tx_busy and rx_busy are both low.
- R6: In the fail state, a pulse less than MIN_GAP cycles after the previous one sets the count to zero. A pulse with spacing from MIN_GAP up to CONSEC_MIN-1, a pulse more than CONSEC_MAX cycles after the previous one, and the first pulse after reset all set the count to one.
- R7: In the pass state, a pulse less than MIN_GAP cycles after the last accepted pulse is ignored. It neither restarts the silence timer nor becomes the reference for the next spacing.
- R8: In the pass state, FAIL_WIN consecutive cycles with no accepted pulse and no pkt_seen move the block to fail at the edge that ends that run.
- R9: While test_disable is 1, the outputs show pass in the same cycle and the state is held in pass. When test_disable is released, the block starts in pass with a fresh silence timer.
- R10: Output encoding: pass gives link_pass_n=0, rx_inhibit=0, tx_inhibit=0, sel_tp=1 (twisted pair). Fail gives the inverse of each of those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_disable | input | 1 | Forces the link to be treated as passing |
| tx_busy | input | 1 | Local data transmission in progress |
| rx_busy | input | 1 | Receive activity on the line |
| lp_seen | input | 1 | One-cycle strobe: link pulse detected |
| pkt_seen | input | 1 | One-cycle strobe: valid complete packet received |
| lp_out | output | 1 | Link pulse to the transmit waveform path |
| link_pass_n | output | 1 | Active-low link pass indicator |
| rx_inhibit | output | 1 | Blocks delivery of received data |
| tx_inhibit | output | 1 | Holds data transmission idle |
| sel_tp | output | 1 | 1 selects twisted pair, 0 falls back to the attachment unit port |

## Verification
A wrong pulse count or spacing reference only shows at the ports when the block changes state. An early or late return to pass appears as link_pass_n toggling one or more cycles away from the expected edge. A spacing timer that restarts on an ignored pulse shows up only once the silence window has run out, so the fault is seen FAIL_WIN cycles later. A bad pulse phase appears on lp_out within one period. The bench therefore compares every output on every cycle, and it also checks the expected state just before and just after each expected transition.

// File: rtl/lit_pkg.sv
package lit_pkg;

    typedef enum logic {
        ST_FAIL = 1'b0,
        ST_PASS = 1'b1
    } link_st_e;

    typedef enum logic [1:0] {
        GAP_SHORT,
        GAP_MID,
        GAP_CONSEC,
        GAP_LONG
    } gap_cls_e;

    typedef struct packed {
        logic pass_n;
        logic rx_inh;
        logic tx_inh;
        logic sel_tp;
    } link_view_t;

    function automatic gap_cls_e classify_gap(input logic [31:0] gap,
                                              input int unsigned min_gap,
                                              input int unsigned cmin,
                                              input int unsigned cmax);
        if (gap < min_gap)    return GAP_SHORT;
        else if (gap < cmin)  return GAP_MID;
        else if (gap <= cmax) return GAP_CONSEC;
        else                  return GAP_LONG;
    endfunction

    function automatic link_view_t view_of(input logic pass);
        link_view_t v;
        v.pass_n = !pass;
        v.rx_inh = !pass;
        v.tx_inh = !pass;
        v.sel_tp = pass;
        return v;
    endfunction

endpackage

// File: rtl/lit_pulse_gen.sv
module lit_pulse_gen #(
    parameter int unsigned PULSE_PERIOD = 800000,
    parameter int unsigned PULSE_WIDTH  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_active,
    output logic lp_out
);
    localparam int unsigned CW = $clog2(PULSE_PERIOD);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (tx_active) begin
            phase_q <= '0;
        end else if (phase_q == CW'(PULSE_PERIOD - 1)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign lp_out = !tx_active && (phase_q >= CW'(PULSE_PERIOD - PULSE_WIDTH));

endmodule

// File: rtl/lit_gap_timer.sv
module lit_gap_timer
    import lit_pkg::*;
#(
    parameter int unsigned MIN_GAP    = 250000,
    parameter int unsigned CONSEC_MIN = 1250000,
    parameter int unsigned CONSEC_MAX = 7500000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    output gap_cls_e cls
);
    localparam int unsigned CAP = CONSEC_MAX + 1;
    localparam int unsigned GW  = $clog2(CAP + 1);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GW'(CAP);
        end else if (restart) begin
            gap_q <= GW'(1);
        end else if (gap_q != GW'(CAP)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign cls = classify_gap(32'(gap_q), MIN_GAP, CONSEC_MIN, CONSEC_MAX);

endmodule

// File: rtl/lit_link_fsm.sv
module lit_link_fsm
    import lit_pkg::*;
#(
    parameter int unsigned FAIL_WIN      = 5000000,
    parameter int unsigned PULSES_NEEDED = 4,
    localparam int unsigned SW  = $clog2(FAIL_WIN),
    localparam int unsigned CNW = $clog2(PULSES_NEEDED + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           test_disable,
    input  logic           tx_busy,
    input  logic           rx_busy,
    input  logic           lp_seen,
    input  logic           pkt_seen,
    input  gap_cls_e       cls,
    output logic           restart,
    output link_st_e       st,
    output logic [SW-1:0]  silence,
    output logic [CNW-1:0] count
);
    logic pkt_pend_q;
    logic accepted;
    logic ready;

    assign accepted = lp_seen && (cls != GAP_SHORT);
    assign restart  = lp_seen && ((st == ST_FAIL) || (cls != GAP_SHORT));
    assign ready    = ((count == CNW'(PULSES_NEEDED)) || pkt_pend_q) && !tx_busy && !rx_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_FAIL;
            silence    <= '0;
            count      <= '0;
            pkt_pend_q <= 1'b0;
        end else begin
            if (st == ST_PASS) begin
                if (accepted || pkt_seen) begin
                    silence <= '0;
                end else if (silence == SW'(FAIL_WIN - 1)) begin
                    st         <= ST_FAIL;
                    silence    <= '0;
                    count      <= '0;
                    pkt_pend_q <= 1'b0;
                end else begin
                    silence <= silence + 1'b1;
                end
            end else begin
                if (pkt_seen) pkt_pend_q <= 1'b1;
                if (lp_seen) begin
                    unique case (cls)
                        GAP_SHORT:  count <= '0;
                        GAP_CONSEC: count <= (count == CNW'(PULSES_NEEDED)) ? count : count + 1'b1;
                        default:    count <= CNW'(1);
                    endcase
                end
                if (ready) begin
                    st         <= ST_PASS;
                    silence    <= '0;
                    count      <= '0;
                    pkt_pend_q <= 1'b0;
                end
            end
            if (test_disable) begin
                st      <= ST_PASS;
                silence <= '0;
            end
        end
    end

endmodule

// File: rtl/link_integrity_ctrl.sv
module link_integrity_ctrl
    import lit_pkg::*;
#(
    parameter int unsigned PULSE_PERIOD  = 800000,
    parameter int unsigned PULSE_WIDTH   = 5,
    parameter int unsigned MIN_GAP       = 250000,
    parameter int unsigned CONSEC_MIN    = 1250000,
    parameter int unsigned CONSEC_MAX    = 7500000,
    parameter int unsigned FAIL_WIN      = 5000000,
    parameter int unsigned PULSES_NEEDED = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic test_disable,
    input  logic tx_busy,
    input  logic rx_busy,
    input  logic lp_seen,
    input  logic pkt_seen,
    output logic lp_out,
    output logic link_pass_n,
    output logic rx_inhibit,
    output logic tx_inhibit,
    output logic sel_tp
);
    localparam int unsigned SW  = $clog2(FAIL_WIN);
    localparam int unsigned CNW = $clog2(PULSES_NEEDED + 1);

    gap_cls_e       gap_cls;
    logic           gap_restart;
    link_st_e       link_st;
    logic [SW-1:0]  silence_cnt;
    logic [CNW-1:0] pulse_cnt;
    link_view_t     view;

    lit_gap_timer #(
        .MIN_GAP   (MIN_GAP),
        .CONSEC_MIN(CONSEC_MIN),
        .CONSEC_MAX(CONSEC_MAX)
    ) gap_i (
        .clk    (clk),
        .rst    (rst),
        .restart(gap_restart),
        .cls    (gap_cls)
    );

    lit_link_fsm #(
        .FAIL_WIN     (FAIL_WIN),
        .PULSES_NEEDED(PULSES_NEEDED)
    ) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .test_disable(test_disable),
        .tx_busy     (tx_busy),
        .rx_busy     (rx_busy),
        .lp_seen     (lp_seen),
        .pkt_seen    (pkt_seen),
        .cls         (gap_cls),
        .restart     (gap_restart),
        .st          (link_st),
        .silence     (silence_cnt),
        .count       (pulse_cnt)
    );

    assign view        = view_of((link_st == ST_PASS) || test_disable);
    assign link_pass_n = view.pass_n;
    assign rx_inhibit  = view.rx_inh;
    assign tx_inhibit  = view.tx_inh;
    assign sel_tp      = view.sel_tp;

    lit_pulse_gen #(
        .PULSE_PERIOD(PULSE_PERIOD),
        .PULSE_WIDTH (PULSE_WIDTH)
    ) gen_i (
        .clk      (clk),
        .rst      (rst),
        .tx_active(tx_busy && !view.tx_inh),
        .lp_out   (lp_out)
    );

endmodule

// File: rtl/lit_checker.sv
module lit_checker
    import lit_pkg::*;
#(
    parameter int unsigned FAIL_WIN      = 5000000,
    parameter int unsigned PULSES_NEEDED = 4,
    localparam int unsigned SW  = $clog2(FAIL_WIN),
    localparam int unsigned CNW = $clog2(PULSES_NEEDED + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           test_disable,
    input logic           tx_busy,
    input logic           rx_busy,
    input logic           lp_seen,
    input logic           pkt_seen,
    input link_st_e       st,
    input gap_cls_e       cls,
    input logic [SW-1:0]  silence,
    input logic [CNW-1:0] count
);

    a_r1_reset_to_fail: assert property (@(posedge clk)
        rst |=> (st == ST_FAIL && count == '0));

    a_r4_exit_needs_idle: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PASS && $past(st) == ST_FAIL && !$past(test_disable) && !$past(rst))
        |-> (!$past(tx_busy) && !$past(rx_busy)));

    a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
        32'(count) <= PULSES_NEEDED);

    a_r7_short_ignored: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PASS && !test_disable && lp_seen && cls == GAP_SHORT && !pkt_seen)
        |=> (st == ST_FAIL || silence != '0));

    a_r8_fail_after_window: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FAIL && $past(st) == ST_PASS && !$past(rst))
        |-> (32'($past(silence)) == FAIL_WIN - 1));

    a_r9_disable_holds_pass: assert property (@(posedge clk) disable iff (rst)
        test_disable |=> (st == ST_PASS));

endmodule

bind link_integrity_ctrl lit_checker #(
    .FAIL_WIN     (FAIL_WIN),
    .PULSES_NEEDED(PULSES_NEEDED)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .test_disable(test_disable),
    .tx_busy     (tx_busy),
    .rx_busy     (rx_busy),
    .lp_seen     (lp_seen),
    .pkt_seen    (pkt_seen),
    .st          (link_st),
    .cls         (gap_cls),
    .silence     (silence_cnt),
    .count       (pulse_cnt)
);

// File: tb/link_integrity_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_integrity_ctrl_tb_top;

    localparam int PER  = 40;
    localparam int W    = 5;
    localparam int MING = 10;
    localparam int CMIN = 30;
    localparam int CMAX = 60;
    localparam int FWIN = 80;
    localparam int NEED = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic test_disable = 1'b0;
    logic tx_busy = 1'b0;
    logic rx_busy = 1'b0;
    logic lp_seen = 1'b0;
    logic pkt_seen = 1'b0;
    logic lp_out, link_pass_n, rx_inhibit, tx_inhibit, sel_tp;

    always #10 clk = ~clk;

    link_integrity_ctrl #(
        .PULSE_PERIOD(PER), .PULSE_WIDTH(W), .MIN_GAP(MING),
        .CONSEC_MIN(CMIN), .CONSEC_MAX(CMAX), .FAIL_WIN(FWIN),
        .PULSES_NEEDED(NEED)
    ) dut_i (
        .clk(clk), .rst(rst), .test_disable(test_disable),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .lp_seen(lp_seen),
        .pkt_seen(pkt_seen), .lp_out(lp_out), .link_pass_n(link_pass_n),
        .rx_inhibit(rx_inhibit), .tx_inhibit(tx_inhibit), .sel_tp(sel_tp)
    );

    int checks = 0;
    int fails  = 0;
    int lp_hi  = 0;
    bit done   = 0;

    // behavioural reference state
    int  m_pass = 0;
    int  m_phase = 0;
    int  m_gap = CMAX + 1;
    int  m_sil = 0;
    int  m_cnt = 0;
    int  m_pend = 0;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit pe, act_tx;
        pe = (m_pass != 0) || test_disable;
        act_tx = tx_busy && pe;
        check("R2 lp_out", lp_out, !act_tx && (m_phase >= PER - W));
        check("R10 link_pass_n", link_pass_n, !pe);
        check("R10 rx_inhibit", rx_inhibit, !pe);
        check("R3 tx_inhibit", tx_inhibit, !pe);
        check("R10 sel_tp", sel_tp, pe);
        if (lp_out) lp_hi++;
    endtask

    task automatic model_step(input bit lp, input bit pkt);
        bit pe, act_tx, acc, rs;
        int d;
        if (rst) begin
            m_pass = 0; m_phase = 0; m_gap = CMAX + 1; m_sil = 0; m_cnt = 0; m_pend = 0;
            return;
        end
        pe = (m_pass != 0) || test_disable;
        act_tx = tx_busy && pe;
        if (act_tx) m_phase = 0;
        else m_phase = (m_phase == PER - 1) ? 0 : m_phase + 1;
        d = m_gap;
        acc = lp && (d >= MING);
        rs = lp && ((m_pass == 0) || d >= MING);
        if (m_pass != 0) begin
            if (acc || pkt) m_sil = 0;
            else if (m_sil == FWIN - 1) begin
                m_pass = 0; m_sil = 0; m_cnt = 0; m_pend = 0;
            end else m_sil++;
        end else begin
            int nc, np;
            nc = m_cnt; np = m_pend;
            if (pkt) np = 1;
            if (lp) begin
                if (d < MING) nc = 0;
                else if (d >= CMIN && d <= CMAX) nc = (m_cnt == NEED) ? NEED : m_cnt + 1;
                else nc = 1;
            end
            if ((m_cnt == NEED || m_pend != 0) && !tx_busy && !rx_busy) begin
                m_pass = 1; m_sil = 0; nc = 0; np = 0;
            end
            m_cnt = nc; m_pend = np;
        end
        if (test_disable) begin
            m_pass = 1; m_sil = 0;
        end
        m_gap = rs ? 1 : ((m_gap == CMAX + 1) ? m_gap : m_gap + 1);
    endtask

    task automatic tick(input bit lp, input bit pkt);
        @(negedge clk);
        lp_seen = lp; pkt_seen = pkt;
        #2;
        compare_all();
        @(posedge clk);
        model_step(lp, pkt);
        #1;
        lp_seen = 1'b0; pkt_seen = 1'b0;
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
    endtask

    task automatic pulse_after(input int n);
        idle_n(n - 1);
        tick(1'b1, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle_n(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 link_pass_n after reset", link_pass_n, 1'b1);
        check("R1 sel_tp after reset", sel_tp, 1'b0);
        check("R1 rx_inhibit after reset", rx_inhibit, 1'b1);

        // R2 pulse duty while idle
        lp_hi = 0;
        idle_n(2 * PER);
        check("R2 pulse cycles in two periods", lp_hi == 2 * W, 1'b1);

        // R6 short pulse wipes count, R4 four qualified pulses
        tick(1'b1, 1'b0);
        pulse_after(40); pulse_after(40);
        pulse_after(5);
        pulse_after(40); pulse_after(40); pulse_after(40);
        idle_n(3);
        check("R6 short pulse reset count, still failing", link_pass_n, 1'b1);
        pulse_after(20);
        pulse_after(40); pulse_after(40);
        idle_n(3);
        check("R6 mid spacing restarts count at one", link_pass_n, 1'b1);
        pulse_after(40);
        idle_n(2);
        check("R4 pass after four consecutive pulses", link_pass_n, 1'b0);
        check("R10 sel_tp in pass", sel_tp, 1'b1);

        // R2 no pulses while sending in pass
        tx_busy = 1'b1;
        lp_hi = 0;
        idle_n(PER);
        check("R2 no pulse while transmitting", lp_hi == 0, 1'b1);
        tx_busy = 1'b0;

        // R7 short pulse ignored, R8 silence window
        pulse_after(30);
        pulse_after(5);
        idle_n(FWIN - 1 - 5);
        check("R8 still passing before window ends", link_pass_n, 1'b0);
        idle_n(2);
        check("R7 ignored pulse did not extend window", link_pass_n, 1'b1);

        // R3 pulses continue in fail even when busy
        tx_busy = 1'b1;
        lp_hi = 0;
        idle_n(PER);
        check("R3 pulses sent while failing and busy", lp_hi == W, 1'b1);
        check("R3 tx_inhibit while failing", tx_inhibit, 1'b1);

        // R5 packet exit waits for idle
        rx_busy = 1'b1;
        tick(1'b0, 1'b1);
        idle_n(5);
        check("R5 packet but busy stays failing", link_pass_n, 1'b1);
        tx_busy = 1'b0; rx_busy = 1'b0;
        idle_n(2);
        check("R5 packet then idle gives pass", link_pass_n, 1'b0);

        // R9 test disable
        idle_n(FWIN + 5);
        check("R8 fail after silence", link_pass_n, 1'b1);
        test_disable = 1'b1;
        #1;
        check("R9 immediate pass on disable", link_pass_n, 1'b0);
        idle_n(FWIN + 10);
        check("R9 pass held while disabled", link_pass_n, 1'b0);
        test_disable = 1'b0;
        idle_n(2);
        check("R9 pass retained after release", link_pass_n, 1'b0);
        idle_n(FWIN + 2);
        check("R8 fail after release window", link_pass_n, 1'b1);

        finish_run();
    end

endmodule